// File: doc/BRIEF.md
# Decimal Split and Register Block Transfer Sequencer

This block performs the memory-moving operations of a small 8-bit virtual machine that has sixteen byte registers and a 16-bit index pointer. When it receives a start pulse with an operation code, a register number X and a base address, it does one of three things. It splits register X into three unpacked decimal digits and writes them to memory. It copies registers 0 through X into consecutive memory bytes. Or it fills registers 0 through X from consecutive memory bytes.

The register file port and the byte memory port both read combinationally and write on the clock edge. The sequencer moves one element per clock in ascending order. When the last write has been committed it raises done for a single cycle and presents the new pointer value. A compatibility input selects whether a block transfer advances the pointer past the bytes it moved. A code outside the three defined operations raises an error pulse and changes nothing.

Top module: `vm_xfer_engine`

## Requirements
- R1: After reset, busy_o, done_o, err_o, mem_we_o and rf_we_o are 0 and inext_o is 0. No write strobe is raised while the block is idle.
- R2: With op_i = 0 (decimal split), the hundreds digit of register X is written to address I, the tens digit to I+1 and the ones digit to I+2. Each digit is an unpacked byte in the range 0 to 9, and the result is exact for every value from 0 to 255.
- R3: The three decimal digit addresses wrap modulo 2^16. With I = 0xFFFF they go to 0xFFFF, 0x0000 and 0x0001.
- R4: With op_i = 1 (block store), registers 0..X are written to addresses I..I+X inclusive, one per clock at ascending addresses, with the addresses wrapping modulo 2^16. No other memory byte changes.
- R5: With op_i = 2 (block load), bytes at I..I+X are written into registers 0..X inclusive. No other register changes, and memory is never written.
- R6: When done_o is high, inext_o equals I+X+1 (mod 2^16) if compat_i was 1 for a block store or load. Otherwise it equals I, and this includes every decimal split. inext_o holds its value while the block is idle.
- R7: done_o is high for exactly one cycle. It appears in the cycle after the (X+1)th clock edge following the start edge for a block transfer, and after the 4th edge for a decimal split.
- R8: op_i = 3 raises err_o for the single cycle after the start edge. It produces no done_o, no write to memory or registers, and no change to inext_o.
- R9: A start pulse that arrives while an operation is in progress is ignored. The running operation's results are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| op_i | input | 2 | Operation: 0 decimal split, 1 block store, 2 block load, 3 invalid |
| xsel_i | input | 4 | Register number X |
| ibase_i | input | 16 | Base address I |
| compat_i | input | 1 | Advance the pointer after block transfers |
| rf_addr_o | output | 4 | Register file address |
| rf_we_o | output | 1 | Register file write enable |
| rf_wdata_o | output | 8 | Register file write data |
| rf_rdata_i | input | 8 | Register file read data (combinational) |
| mem_addr_o | output | 16 | Memory byte address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data (combinational) |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle invalid-operation pulse |
| inext_o | output | 16 | Updated index pointer |

## Verification
The hardest cases to reach from the ports are transfers whose address range crosses the top of the 16-bit space, and a start request that lands in the middle of a running transfer. The first needs a base address just below 0xFFFF together with a large X. The second needs a second start issued a few cycles after the first and before done. Directed cases cover both: a full 16-register store and load based at 0xFFF8 and 0xFFFF, a decimal split at 0xFFFF, and a load request injected during a long store. The decimal digit boundaries 9/10, 99/100 and 255 are set through the register port before a split is started. Seeded random operations with random X, base and mode fill in the rest. Each one is compared against a whole-memory and whole-register-file expectation that the bench computes from a snapshot taken before the start.

// File: rtl/vmx_pkg.sv
package vmx_pkg;
   typedef enum logic [1:0] {
      OPC_DIGITS = 2'd0,
      OPC_SAVE   = 2'd1,
      OPC_FILL   = 2'd2,
      OPC_RSVD   = 2'd3
   } opc_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_RUN,
      ST_DONE,
      ST_ERR
   } st_e;
endpackage

// File: rtl/vmx_dec_split.sv
// Combinational binary to three unpacked decimal digits.
module vmx_dec_split #(
   parameter int DW       = 8,
   parameter int DIV_KIND = 1   // 0: plain divide, 1: reciprocal multiply
) (
   input  logic [DW-1:0] val_i,
   output logic [3:0]    hund_o,
   output logic [3:0]    tens_o,
   output logic [3:0]    ones_o
);
   if (DW != 8) begin : g_bad_dw
      $error("vmx_dec_split supports only DW == 8");
   end

   if (DIV_KIND == 0) begin : g_div
      logic [DW-1:0] tenths;
      assign tenths = val_i / DW'(10);
      assign hund_o = 4'(tenths / DW'(10));
      assign tens_o = 4'(tenths % DW'(10));
      assign ones_o = 4'(val_i % DW'(10));
   end else begin : g_recip
      // floor(v*205/2048) equals floor(v/10) for every v below 1029
      logic [15:0] tenths;
      logic [15:0] hundreds;
      assign tenths   = 16'((16'(val_i) * 16'd205) >> 11);
      assign hundreds = 16'((tenths * 16'd205) >> 11);
      assign hund_o   = 4'(hundreds);
      assign tens_o   = 4'(tenths - hundreds * 16'd10);
      assign ones_o   = 4'(16'(val_i) - tenths * 16'd10);
   end
endmodule

// File: rtl/vmx_seq_ctrl.sv
// Operation sequencer: accepts a request, steps an element counter.
module vmx_seq_ctrl
   import vmx_pkg::*;
#(
   parameter int RW = 4,
   parameter int CW = (RW > 2) ? RW : 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [1:0]    op_i,
   input  logic [RW-1:0] xsel_i,
   output st_e           st_o,
   output opc_e          op_o,
   output logic [RW-1:0] x_o,
   output logic [CW-1:0] cnt_o,
   output logic          accept_o,
   output logic          finish_o
);
   st_e           st_q;
   opc_e          op_q;
   logic [RW-1:0] x_q;
   logic [CW-1:0] cnt_q;
   logic          last;

   assign last     = (op_q == OPC_DIGITS) ? (cnt_q == CW'(2)) : (cnt_q == CW'(x_q));
   assign accept_o = (st_q == ST_IDLE) && start_i;
   assign finish_o = (st_q == ST_RUN) && last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         op_q  <= OPC_DIGITS;
         x_q   <= '0;
         cnt_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  op_q  <= opc_e'(op_i);
                  x_q   <= xsel_i;
                  cnt_q <= '0;
                  case (opc_e'(op_i))
                     OPC_RSVD:   st_q <= ST_ERR;
                     OPC_DIGITS: st_q <= ST_FETCH;
                     default:    st_q <= ST_RUN;
                  endcase
               end
            end
            ST_FETCH: st_q <= ST_RUN;
            ST_RUN: begin
               if (last) st_q <= ST_DONE;
               else      cnt_q <= cnt_q + CW'(1);
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign st_o  = st_q;
   assign op_o  = op_q;
   assign x_o   = x_q;
   assign cnt_o = cnt_q;
endmodule

// File: rtl/vmx_addr_gen.sv
// Base pointer capture, element address and updated pointer.
module vmx_addr_gen #(
   parameter int AW = 16,
   parameter int RW = 4,
   parameter int CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept_i,
   input  logic          finish_i,
   input  logic [AW-1:0] ibase_i,
   input  logic          compat_i,
   input  logic          block_i,
   input  logic [RW-1:0] x_i,
   input  logic [CW-1:0] cnt_i,
   output logic [AW-1:0] addr_o,
   output logic [AW-1:0] inext_o
);
   logic [AW-1:0] base_q;
   logic          compat_q;
   logic [AW-1:0] inext_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q   <= '0;
         compat_q <= 1'b0;
         inext_q  <= '0;
      end else begin
         if (accept_i) begin
            base_q   <= ibase_i;
            compat_q <= compat_i;
         end
         if (finish_i) begin
            if (compat_q && block_i) inext_q <= base_q + AW'(x_i) + AW'(1);
            else                     inext_q <= base_q;
         end
      end
   end

   assign addr_o  = base_q + AW'(cnt_i);
   assign inext_o = inext_q;
endmodule

// File: rtl/vm_xfer_engine.sv
module vm_xfer_engine
   import vmx_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter int NREGS    = 16,
   parameter int DIV_KIND = 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic [1:0]               op_i,
   input  logic [$clog2(NREGS)-1:0] xsel_i,
   input  logic [AW-1:0]            ibase_i,
   input  logic                     compat_i,
   output logic [$clog2(NREGS)-1:0] rf_addr_o,
   output logic                     rf_we_o,
   output logic [DW-1:0]            rf_wdata_o,
   input  logic [DW-1:0]            rf_rdata_i,
   output logic [AW-1:0]            mem_addr_o,
   output logic                     mem_we_o,
   output logic [DW-1:0]            mem_wdata_o,
   input  logic [DW-1:0]            mem_rdata_i,
   output logic                     busy_o,
   output logic                     done_o,
   output logic                     err_o,
   output logic [AW-1:0]            inext_o
);
   localparam int RW = $clog2(NREGS);
   localparam int CW = (RW > 2) ? RW : 2;

   if (NREGS < 2 || (1 << RW) != NREGS) begin : g_chk_nregs
      $error("NREGS must be a power of two of at least 2");
   end
   if (AW < RW) begin : g_chk_aw
      $error("AW must cover the register count");
   end
   if (DW != 8) begin : g_chk_dw
      $error("DW must be 8");
   end

   st_e           st;
   opc_e          op_q;
   logic [RW-1:0] x_q;
   logic [CW-1:0] cnt;
   logic          accept;
   logic          finish;
   logic          run;
   logic          run_digits;
   logic [DW-1:0] val_q;
   logic [3:0]    hund, tens, ones;
   logic [3:0]    digit;

   vmx_seq_ctrl #(.RW(RW), .CW(CW)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .op_i     (op_i),
      .xsel_i   (xsel_i),
      .st_o     (st),
      .op_o     (op_q),
      .x_o      (x_q),
      .cnt_o    (cnt),
      .accept_o (accept),
      .finish_o (finish)
   );

   vmx_addr_gen #(.AW(AW), .RW(RW), .CW(CW)) u_addr (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .finish_i (finish),
      .ibase_i  (ibase_i),
      .compat_i (compat_i),
      .block_i  (op_q != OPC_DIGITS),
      .x_i      (x_q),
      .cnt_i    (cnt),
      .addr_o   (mem_addr_o),
      .inext_o  (inext_o)
   );

   vmx_dec_split #(.DW(DW), .DIV_KIND(DIV_KIND)) u_split (
      .val_i  (val_q),
      .hund_o (hund),
      .tens_o (tens),
      .ones_o (ones)
   );

   // capture the source register once, so the digits are stable for three writes
   always_ff @(posedge clk) begin
      if (!rst_n)               val_q <= '0;
      else if (st == ST_FETCH)  val_q <= rf_rdata_i;
   end

   always_comb begin
      case (cnt[1:0])
         2'd0:    digit = hund;
         2'd1:    digit = tens;
         default: digit = ones;
      endcase
   end

   assign run        = (st == ST_RUN);
   assign run_digits = run && (op_q == OPC_DIGITS);

   assign rf_addr_o   = (st == ST_FETCH) ? x_q : cnt[RW-1:0];
   assign rf_we_o     = run && (op_q == OPC_FILL);
   assign rf_wdata_o  = mem_rdata_i;
   assign mem_we_o    = run && (op_q != OPC_FILL);
   assign mem_wdata_o = (op_q == OPC_DIGITS) ? DW'(digit) : rf_rdata_i;

   assign busy_o = (st == ST_FETCH) || run;
   assign done_o = (st == ST_DONE);
   assign err_o  = (st == ST_ERR);
endmodule

// File: rtl/vm_xfer_engine_chk.sv
module vm_xfer_engine_chk #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          err,
   input logic          mem_we,
   input logic          rf_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic [AW-1:0] inext,
   input logic          digits_run
);
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_we && !rf_we));

   p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (digits_run && mem_we) |-> (mem_wdata <= DW'(9)));

   p_addr_ascend_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

   p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && rf_we));

   p_inext_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy)) |-> $stable(inext));

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!mem_we && !rf_we && !done));

   p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
endmodule

bind vm_xfer_engine vm_xfer_engine_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy       (busy_o),
   .done       (done_o),
   .err        (err_o),
   .mem_we     (mem_we_o),
   .rf_we      (rf_we_o),
   .mem_addr   (mem_addr_o),
   .mem_wdata  (mem_wdata_o),
   .inext      (inext_o),
   .digits_run (run_digits)
);

// File: tb/vm_xfer_engine_bench.sv
module vm_xfer_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  op_i = 2'd0;
   logic [3:0]  xsel_i = 4'd0;
   logic [15:0] ibase_i = 16'd0;
   logic        compat_i = 1'b0;
   logic [3:0]  rf_addr_o;
   logic        rf_we_o;
   logic [7:0]  rf_wdata_o, rf_rdata_i;
   logic [15:0] mem_addr_o;
   logic        mem_we_o;
   logic [7:0]  mem_wdata_o, mem_rdata_i;
   logic        busy_o, done_o, err_o;
   logic [15:0] inext_o;

   logic        tb_rwe = 1'b0;
   logic [3:0]  tb_ra = 4'd0;
   logic [7:0]  tb_rd = 8'd0;

   logic [7:0]  mem  [256];
   logic [7:0]  regs [16];
   logic [7:0]  s_mem [256];
   logic [7:0]  s_regs [16];
   logic [7:0]  e_mem [256];
   logic [7:0]  e_regs [16];

   int n_chk = 0;
   int n_fail = 0;
   bit ended = 0;

   always #2 clk = ~clk;

   vm_xfer_engine u_vm_xfer_engine (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .xsel_i(xsel_i),
      .ibase_i(ibase_i), .compat_i(compat_i), .rf_addr_o(rf_addr_o), .rf_we_o(rf_we_o),
      .rf_wdata_o(rf_wdata_o), .rf_rdata_i(rf_rdata_i), .mem_addr_o(mem_addr_o),
      .mem_we_o(mem_we_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .inext_o(inext_o)
   );

   // bench memory (256-byte window, address wraps on low byte) and register file
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 256; k++) mem[k] <= 8'(k * 37 + 11);
         for (int k = 0; k < 16; k++) regs[k] <= 8'd0;
      end else begin
         if (mem_we_o) mem[mem_addr_o[7:0]] <= mem_wdata_o;
         if (rf_we_o) regs[rf_addr_o] <= rf_wdata_o;
         else if (tb_rwe) regs[tb_ra] <= tb_rd;
      end
   end
   assign mem_rdata_i = mem[mem_addr_o[7:0]];
   assign rf_rdata_i  = regs[rf_addr_o];

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic set_reg(input int idx, input int val);
      @(negedge clk);
      tb_rwe = 1'b1; tb_ra = 4'(idx); tb_rd = 8'(val);
      @(negedge clk);
      tb_rwe = 1'b0;
   endtask

   task automatic rand_regs();
      for (int k = 0; k < 16; k++) set_reg(k, int'($urandom % 256));
   endtask

   // op: 0 split, 1 store, 2 load, 3 invalid. poke: inject a load start mid-run.
   task automatic run_op(input int op, input int x, input int ib, input bit cm,
                         input bit poke, input string req);
      int k;
      int v;
      int e_inext;
      int e_lat;
      int mism;
      int prev_inext;
      prev_inext = int'(inext_o);
      for (int a = 0; a < 256; a++) begin s_mem[a] = mem[a]; e_mem[a] = mem[a]; end
      for (int r = 0; r < 16; r++) begin s_regs[r] = regs[r]; e_regs[r] = regs[r]; end
      e_inext = ib;
      e_lat = x + 1;
      if (op == 0) begin
         v = int'(s_regs[x]);
         e_mem[(ib) & 255]     = 8'(v / 100);
         e_mem[(ib + 1) & 255] = 8'((v / 10) % 10);
         e_mem[(ib + 2) & 255] = 8'(v % 10);
         e_lat = 4;
      end else if (op == 1) begin
         for (int r = 0; r <= x; r++) e_mem[(ib + r) & 255] = s_regs[r];
      end else if (op == 2) begin
         for (int r = 0; r <= x; r++) e_regs[r] = s_mem[(ib + r) & 255];
      end
      if (cm && (op == 1 || op == 2)) e_inext = (ib + x + 1) & 16'hFFFF;
      if (op == 3) e_inext = prev_inext;

      @(negedge clk);
      start_i = 1'b1; op_i = 2'(op); xsel_i = 4'(x); ibase_i = 16'(ib); compat_i = cm;
      @(negedge clk);
      start_i = 1'b0;
      k = 0;
      while (!done_o && !err_o && k < 40) begin
         if (poke && k == 1) begin
            start_i = 1'b1; op_i = 2'd2; xsel_i = 4'd15; ibase_i = 16'h0040;
         end
         @(negedge clk);
         start_i = 1'b0;
         k++;
      end
      if (op == 3) begin
         chk(err_o == 1'b1 && k == 0, "R8", "err pulse cycle", k, 0);
         @(negedge clk);
         chk(err_o == 1'b0, "R8", "err width", int'(err_o), 0);
         repeat (3) begin
            chk(done_o == 1'b0, "R8", "no done", int'(done_o), 0);
            @(negedge clk);
         end
      end else begin
         chk(done_o == 1'b1 && k == e_lat, "R7", "done latency", k, e_lat);
         chk(inext_o == 16'(e_inext), "R6", "updated pointer", int'(inext_o), e_inext);
         @(negedge clk);
         chk(done_o == 1'b0, "R7", "done width", int'(done_o), 0);
      end
      mism = 0;
      for (int a = 0; a < 256; a++) if (mem[a] !== e_mem[a]) begin
         if (mism == 0) chk(0, req, $sformatf("memory byte %0d", a), int'(mem[a]), int'(e_mem[a]));
         mism++;
      end
      if (mism == 0) chk(1, req, "memory", 0, 0);
      mism = 0;
      for (int r = 0; r < 16; r++) if (regs[r] !== e_regs[r]) begin
         if (mism == 0) chk(0, req, $sformatf("register %0d", r), int'(regs[r]), int'(e_regs[r]));
         mism++;
      end
      if (mism == 0) chk(1, req, "registers", 0, 0);
      chk(inext_o == 16'(e_inext), "R6", "pointer held while idle", int'(inext_o), e_inext);
   endtask

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!busy_o && !done_o && !err_o, "R1", "idle flags", int'({busy_o, done_o, err_o}), 0);
      chk(!mem_we_o && !rf_we_o, "R1", "no strobes", int'({mem_we_o, rf_we_o}), 0);
      chk(inext_o == 16'd0, "R1", "pointer reset", int'(inext_o), 0);

      // R2: digit boundaries
      set_reg(5, 0);   run_op(0, 5, 16'h0010, 1'b0, 1'b0, "R2");
      set_reg(5, 9);   run_op(0, 5, 16'h0020, 1'b1, 1'b0, "R2");
      set_reg(7, 10);  run_op(0, 7, 16'h0030, 1'b0, 1'b0, "R2");
      set_reg(7, 99);  run_op(0, 7, 16'h1234, 1'b0, 1'b0, "R2");
      set_reg(0, 100); run_op(0, 0, 16'h0050, 1'b0, 1'b0, "R2");
      set_reg(15, 255); run_op(0, 15, 16'h0060, 1'b1, 1'b0, "R2");
      // R3: wrap of the digit addresses
      set_reg(3, 147); run_op(0, 3, 16'hFFFF, 1'b1, 1'b0, "R3");

      rand_regs();
      // R4: store, single register and full block across the top of memory
      run_op(1, 0, 16'h0080, 1'b1, 1'b0, "R4");
      run_op(1, 15, 16'hFFF8, 1'b1, 1'b0, "R4");
      run_op(1, 6, 16'h0100, 1'b0, 1'b0, "R4");
      // R5: load, full block with wrapping pointer, and partial without advance
      run_op(2, 15, 16'hFFFF, 1'b1, 1'b0, "R5");
      rand_regs();
      run_op(2, 3, 16'h0090, 1'b0, 1'b0, "R5");
      run_op(2, 0, 16'h00A0, 1'b1, 1'b0, "R5");
      // R8: invalid code
      run_op(3, 9, 16'h0000, 1'b1, 1'b0, "R8");
      // R9: start while busy is ignored
      rand_regs();
      run_op(1, 12, 16'h00C0, 1'b1, 1'b1, "R9");

      // random mix covering R2, R4, R5, R6
      for (int t = 0; t < 40; t++) begin
         int op;
         op = int'($urandom % 3);
         if (t % 4 == 0) rand_regs();
         run_op(op, int'($urandom % 16), int'($urandom % 65536), 1'($urandom % 2),
                1'b0, (op == 0) ? "R2" : (op == 1) ? "R4" : "R5");
      end
      run_op(3, 2, 16'h4444, 1'b0, 1'b0, "R8");

      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!ended) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule